// File: doc/BRIEF.md
# Legacy Memory Window Router

This block sits between a processor-side request channel and three memory targets on a 20-bit legacy address space: a BIOS image window, a video memory window and a main memory port. Each accepted byte, word or doubleword request is classified by address into one region. The region gives the target, the offset passed to it and the way the response is built. A short identification area at the very top of the space is answered from constants held in the block. When video emulation is on, the video range is cut off entirely.

A request is taken when `req_valid` is high in the IDLE state. The block moves to RESP for exactly one cycle. In that cycle it presents the target strobe, select and offset, and it returns `rsp_rdata` with `rsp_valid`. The target returns read data combinationally in that same cycle. The FSM has three states. IDLE goes to RESP on a valid request. RESP goes back to IDLE after a normal access. RESP goes to HALT after an access that set the halt flag. HALT has no exit except reset.

The BIOS window limit, the memory size and the video-emulation enable are configuration inputs. They are sampled when a request is accepted.

Top module: `lmw_router`

## Requirements
- R1: `req_ready` is high only in IDLE. An accepted request gives `rsp_valid` for exactly the next cycle. `req_ready` is low in that cycle. `tgt_valid` is high only in a response cycle whose target is not none.
- R2: Addresses from 0xC0000 up to and including `cfg_bios_limit` select the BIOS target (`tgt_sel`=1) with offset address-0xC0000.
- R3: Addresses above `cfg_bios_limit` and below 0xD0000 select main memory (`tgt_sel`=3) at offset 0, and `addr_warn` is high in that response cycle.
- R4: Addresses 0xA0000..0xBFFFF with emulation off select the video target (`tgt_sel`=2) with offset address-0xA0000.
- R5: With `cfg_video_emu`=1, reads in 0xA0000..0xBFFFF return 0 and writes there reach no target (`tgt_valid`=0).
- R6: Addresses 0xFFFF5..0xFFFFF use no target. The byte at 0xFFFF5+i reads as character i of "03/27/01" for i<8. The byte at 0xFFFFD reads as 0x00, at 0xFFFFE as 0xFC, and at 0xFFFFF as 0x00. Lanes past 0xFFFFF read 0. Writes there are dropped.
- R7: Any other address at or above `cfg_mem_size` goes to main memory at offset 0 and raises `halt` from its response cycle onward. `halt` stays high and `req_ready` stays low until reset.
- R8: All remaining addresses select main memory with offset equal to the address.
- R9: `req_size` 0 is a byte, 1 a word, and 2 or 3 a doubleword. Byte lane k (bits 8k+7:8k) holds address+k (little-endian). `rsp_rdata` lanes beyond the size read 0. Write data, write flag and size are passed to the target unchanged.
- R10: Regions are evaluated in this priority: video emulation, then BIOS window, gap, video, identification, out-of-range, main.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | 20 | Byte address |
| req_size | input | 2 | 0 byte, 1 word, 2/3 doubleword |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Little-endian write data |
| cfg_bios_limit | input | 20 | Last address of the BIOS window |
| cfg_mem_size | input | 21 | Main memory size in bytes |
| cfg_video_emu | input | 1 | Suppress the video range |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | 32 | Read data, size-masked |
| tgt_valid | output | 1 | Target access strobe |
| tgt_sel | output | 2 | 0 none, 1 BIOS, 2 video, 3 main |
| tgt_offset | output | 20 | Offset within the selected target |
| tgt_write | output | 1 | Write flag to target |
| tgt_size | output | 2 | Access size to target |
| tgt_wdata | output | 32 | Write data to target |
| tgt_rdata | input | 32 | Read data from the selected target, same cycle |
| addr_warn | output | 1 | Access fell in the gap after the BIOS window |
| halt | output | 1 | Sticky out-of-range flag |

## Verification
The bench builds the block with its default 20-bit address and 32-bit data widths. It sets the BIOS window to end at 0xC7FFF and main memory to 512 KiB. This makes the gap, the top of the window, the last main-memory byte and an out-of-range address all reachable. Because the memory is smaller than 0xA0000, the video and identification ranges lie above the memory size, so the region priority is exercised. Emulation is toggled between requests, and a final reset shows that the halt state is cleared.

// File: rtl/lmw_pkg.sv
package lmw_pkg;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_BIOS  = 2'd1,
        TGT_VIDEO = 2'd2,
        TGT_MAIN  = 2'd3
    } tgt_e;

    typedef enum logic [2:0] {
        RG_BIOS, RG_GAP, RG_VID, RG_VID_EMU, RG_ID, RG_OOR, RG_MAIN
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_RESP, ST_HALT
    } state_e;

    localparam logic [19:0] BIOS_BASE = 20'hC0000;
    localparam logic [19:0] GAP_END   = 20'hD0000;
    localparam logic [19:0] VID_BASE  = 20'hA0000;
    localparam logic [19:0] VID_LAST  = 20'hBFFFF;
    localparam logic [19:0] ID_BASE   = 20'hFFFF5;

    localparam logic [63:0] ID_DATE     = "03/27/01";
    localparam logic [7:0]  ID_MODEL    = 8'hFC;
    localparam logic [7:0]  ID_SUBMODEL = 8'h00;

endpackage

// File: rtl/lmw_decode.sv
module lmw_decode
    import lmw_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] bios_limit,
    input  logic [ADDR_W:0]   mem_size,
    input  logic              video_emu,
    output region_e           region,
    output logic [ADDR_W-1:0] offset
);
    localparam logic [ADDR_W-1:0] L_BIOS = ADDR_W'(BIOS_BASE);
    localparam logic [ADDR_W-1:0] L_GAPE = ADDR_W'(GAP_END);
    localparam logic [ADDR_W-1:0] L_VIDB = ADDR_W'(VID_BASE);
    localparam logic [ADDR_W-1:0] L_VIDL = ADDR_W'(VID_LAST);
    localparam logic [ADDR_W-1:0] L_IDB  = ADDR_W'(ID_BASE);

    logic in_video;
    assign in_video = (addr >= L_VIDB) && (addr <= L_VIDL);

    // Priority chain: emulation cut-off, BIOS, gap, video, id, range, main
    always_comb begin
        region = RG_MAIN;
        offset = addr;
        if (video_emu && in_video) begin
            region = RG_VID_EMU;
            offset = '0;
        end else if (addr >= L_BIOS && addr <= bios_limit) begin
            region = RG_BIOS;
            offset = addr - L_BIOS;
        end else if (addr > bios_limit && addr < L_GAPE) begin
            region = RG_GAP;
            offset = '0;
        end else if (in_video) begin
            region = RG_VID;
            offset = addr - L_VIDB;
        end else if (addr >= L_IDB) begin
            region = RG_ID;
            offset = '0;
        end else if ({1'b0, addr} >= mem_size) begin
            region = RG_OOR;
            offset = '0;
        end
    end

endmodule

// File: rtl/lmw_idrom.sv
module lmw_idrom
    import lmw_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    localparam int LANES = DATA_W / 8;
    localparam logic [ADDR_W-1:0] L_IDB = ADDR_W'(ID_BASE);

    function automatic logic [7:0] id_byte(input logic [ADDR_W-1:0] i);
        if (i < ADDR_W'(8))       return ID_DATE[8*(7 - int'(i[2:0])) +: 8];
        else if (i == ADDR_W'(9)) return ID_MODEL;
        else if (i == ADDR_W'(10)) return ID_SUBMODEL;
        else                      return 8'h00;
    endfunction

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [ADDR_W-1:0] idx;
        assign idx = addr - L_IDB + ADDR_W'(k);
        assign data[8*k +: 8] = id_byte(idx);
    end

endmodule

// File: rtl/lmw_router.sv
module lmw_router
    import lmw_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [ADDR_W-1:0] cfg_bios_limit,
    input  logic [ADDR_W:0]   cfg_mem_size,
    input  logic              cfg_video_emu,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              tgt_valid,
    output logic [1:0]        tgt_sel,
    output logic [ADDR_W-1:0] tgt_offset,
    output logic              tgt_write,
    output logic [1:0]        tgt_size,
    output logic [DATA_W-1:0] tgt_wdata,
    input  logic [DATA_W-1:0] tgt_rdata,
    output logic              addr_warn,
    output logic              halt
);
    localparam int LANES = DATA_W / 8;

    state_e            state_q, state_d;
    region_e           region_d, region_q;
    logic [ADDR_W-1:0] off_d, off_q, addr_q;
    logic [1:0]        size_q;
    logic              wr_q, halt_q, accept;
    logic [DATA_W-1:0] wdata_q, id_data, raw_data, lane_mask;
    tgt_e              sel;

    lmw_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr       (req_addr),
        .bios_limit (cfg_bios_limit),
        .mem_size   (cfg_mem_size),
        .video_emu  (cfg_video_emu),
        .region     (region_d),
        .offset     (off_d)
    );

    lmw_idrom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_idrom (
        .addr (addr_q),
        .data (id_data)
    );

    assign accept = req_valid && (state_q == ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: state_d = halt_q ? ST_HALT : ST_IDLE;
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_IDLE;
        endcase
    end

    // Request capture and sticky halt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            region_q <= RG_MAIN;
            off_q    <= '0;
            addr_q   <= '0;
            size_q   <= '0;
            wr_q     <= 1'b0;
            wdata_q  <= '0;
            halt_q   <= 1'b0;
        end else if (accept) begin
            region_q <= region_d;
            off_q    <= off_d;
            addr_q   <= req_addr;
            size_q   <= req_size;
            wr_q     <= req_write;
            wdata_q  <= req_wdata;
            if (region_d == RG_OOR) halt_q <= 1'b1;
        end
    end

    // Lane enables from the access size
    for (genvar k = 0; k < LANES; k++) begin : g_mask
        logic on;
        if (k == 0)      begin : g_b assign on = 1'b1; end
        else if (k == 1) begin : g_w assign on = (size_q != 2'd0); end
        else             begin : g_d assign on = size_q[1]; end
        assign lane_mask[8*k +: 8] = {8{on}};
    end

    // Outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_RESP);
        unique case (region_q)
            RG_BIOS:                 sel = TGT_BIOS;
            RG_VID:                  sel = TGT_VIDEO;
            RG_GAP, RG_OOR, RG_MAIN: sel = TGT_MAIN;
            default:                 sel = TGT_NONE;
        endcase
        tgt_sel    = sel;
        tgt_valid  = rsp_valid && (sel != TGT_NONE);
        tgt_offset = off_q;
        tgt_write  = wr_q;
        tgt_size   = size_q;
        tgt_wdata  = wdata_q;
        if (wr_q)                  raw_data = '0;
        else if (region_q == RG_ID) raw_data = id_data;
        else if (sel != TGT_NONE)  raw_data = tgt_rdata;
        else                       raw_data = '0;
        rsp_rdata = raw_data & lane_mask;
        addr_warn = rsp_valid && (region_q == RG_GAP);
        halt      = halt_q;
    end

endmodule

// File: rtl/lmw_router_chk.sv
module lmw_router_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_write,
    input logic [ADDR_W-1:0] cfg_bios_limit,
    input logic [ADDR_W:0]   cfg_mem_size,
    input logic              cfg_video_emu,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              tgt_valid,
    input logic [1:0]        tgt_sel,
    input logic [ADDR_W-1:0] tgt_offset,
    input logic              addr_warn,
    input logic              halt
);
    logic acc;
    assign acc = req_valid && req_ready;

    a_r1_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);
    a_r1_busy_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    a_r1_strobe_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> rsp_valid);
    a_r3_gap_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_addr >= 20'hC0000 && req_addr > cfg_bios_limit && req_addr < 20'hD0000)
        |=> (addr_warn && tgt_sel == 2'd3 && tgt_offset == '0));
    a_r5_emu_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cfg_video_emu && req_addr >= 20'hA0000 && req_addr <= 20'hBFFFF)
        |=> (!tgt_valid && rsp_rdata == '0));
    a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);
    a_r7_halt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !req_ready);
    a_r8_main_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && {1'b0, req_addr} < cfg_mem_size && req_addr < 20'hA0000)
        |=> (tgt_valid && tgt_sel == 2'd3 && tgt_offset == $past(req_addr)));
    a_r9_write_no_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write) |=> (rsp_rdata == '0));

endmodule

bind lmw_router lmw_router_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_addr       (req_addr),
    .req_write      (req_write),
    .cfg_bios_limit (cfg_bios_limit),
    .cfg_mem_size   (cfg_mem_size),
    .cfg_video_emu  (cfg_video_emu),
    .rsp_valid      (rsp_valid),
    .rsp_rdata      (rsp_rdata),
    .tgt_valid      (tgt_valid),
    .tgt_sel        (tgt_sel),
    .tgt_offset     (tgt_offset),
    .addr_warn      (addr_warn),
    .halt           (halt)
);

// File: tb/lmw_router_bench.sv
`timescale 1ns/1ps
module lmw_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, cfg_video_emu = 1'b0;
    logic        req_ready, rsp_valid, tgt_valid, tgt_write, addr_warn, halt;
    logic [19:0] req_addr = '0, tgt_offset;
    logic [19:0] cfg_bios_limit = 20'hC7FFF;
    logic [20:0] cfg_mem_size = 21'h80000;
    logic [1:0]  req_size = '0, tgt_sel, tgt_size;
    logic [31:0] req_wdata = '0, rsp_rdata, tgt_wdata, tgt_rdata;

    int checks = 0, errors = 0;
    bit halted = 1'b0;

    always #2 clk = ~clk;

    assign tgt_rdata = {tgt_offset[11:0], tgt_offset} ^ {30'd0, tgt_sel};

    lmw_router u_lmw_router (.*);

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] id_at(input int i);
        string s = "03/27/01";
        if (i < 8) return s[i];
        if (i == 9) return 8'hFC;
        return 8'h00;
    endfunction

    task automatic run(input int a, input int sz, input bit wr, input logic [31:0] wd, input string tag);
        int sel = 0, off = 0, nb;
        bit warn = 0, oor = 0, is_id = 0;
        logic [31:0] rd = '0;
        if (cfg_video_emu && a >= 'hA0000 && a <= 'hBFFFF) sel = 0;
        else if (a >= 'hC0000 && a <= int'(cfg_bios_limit)) begin sel = 1; off = a - 'hC0000; end
        else if (a > int'(cfg_bios_limit) && a < 'hD0000) begin sel = 3; warn = 1; end
        else if (a >= 'hA0000 && a <= 'hBFFFF) begin sel = 2; off = a - 'hA0000; end
        else if (a >= 'hFFFF5) is_id = 1;
        else if (a >= int'(cfg_mem_size)) begin sel = 3; oor = 1; end
        else begin sel = 3; off = a; end
        if (!wr) begin
            if (is_id) for (int k = 0; k < 4; k++) rd[8*k +: 8] = id_at(a - 'hFFFF5 + k);
            else if (sel != 0) rd = {off[11:0], off[19:0]} ^ sel;
        end
        nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        for (int k = 0; k < 4; k++) if (k >= nb) rd[8*k +: 8] = 8'h00;
        @(negedge clk);
        req_valid = 1; req_addr = a[19:0]; req_size = sz[1:0]; req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        halted = halted | oor;
        chk(rsp_valid == 1'b1, {tag, " R1 rsp_valid"}, rsp_valid, 1);
        chk(req_ready == 1'b0, {tag, " R1 busy"}, req_ready, 0);
        chk(tgt_valid == (sel != 0), {tag, " tgt_valid"}, tgt_valid, sel != 0);
        if (sel != 0) begin
            chk(tgt_sel == sel[1:0], {tag, " tgt_sel"}, tgt_sel, sel);
            chk(tgt_offset == off[19:0], {tag, " tgt_offset"}, tgt_offset, off);
            chk(tgt_write == wr && tgt_size == sz[1:0], {tag, " R9 write/size"}, {tgt_write, tgt_size}, {wr, sz[1:0]});
            if (wr) chk(tgt_wdata == wd, {tag, " R9 wdata"}, tgt_wdata, wd);
        end
        chk(rsp_rdata == rd, {tag, " rdata"}, rsp_rdata, rd);
        chk(addr_warn == warn, {tag, " R3 warn"}, addr_warn, warn);
        chk(halt == halted, {tag, " R7 halt"}, halt, halted);
        @(negedge clk);
        chk(rsp_valid == 1'b0 && req_ready == !halted, {tag, " R1 after"}, {rsp_valid, req_ready}, {1'b0, !halted});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !tgt_valid && !halt && !addr_warn, "reset R1",
            {req_ready, rsp_valid, tgt_valid, halt, addr_warn}, 5'b10000);
        run('hC0010, 1, 0, 0, "R2 bios word");
        run('hC7FFF, 0, 0, 0, "R2 bios limit byte R9");
        run('hC8000, 2, 0, 0, "R3 gap start");
        run('hCFFFF, 2, 1, 32'h11223344, "R3 gap write");
        run('hA0000, 2, 0, 0, "R4 video base R10");
        run('hBFFFF, 0, 1, 32'h000000AB, "R4 video write");
        cfg_video_emu = 1;
        run('hA0100, 2, 0, 0, "R5 emu read");
        run('hB0000, 2, 1, 32'hDEADBEEF, "R5 emu write");
        cfg_video_emu = 0;
        run('hFFFF5, 2, 0, 0, "R6 date head R10");
        run('hFFFFC, 3, 0, 0, "R6 tail dword R9");
        run('hFFFFE, 0, 0, 0, "R6 model");
        run('hFFFFF, 1, 0, 0, "R6 submodel word");
        run('hFFFF8, 2, 1, 32'h55555555, "R6 write dropped");
        run('h00400, 2, 0, 0, "R8 main dword");
        run('h12345, 1, 1, 32'hCAFE1234, "R8 main write R9");
        run('h7FFFF, 0, 0, 0, "R8 main last");
        run('h80000, 2, 0, 0, "R7 out of range");
        req_valid = 1; req_addr = 20'h00010;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!req_ready && !rsp_valid && halt, "R7 halted hold", {req_ready, rsp_valid, halt}, 3'b001);
        end
        req_valid = 0;
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        halted = 0;
        @(negedge clk);
        chk(!halt && req_ready, "R7 reset clears", {halt, req_ready}, 2'b01);
        run('h00010, 0, 0, 0, "R8 after reset");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule